// File: doc/BRIEF.md
# Eight-Function ALU with Complemented Operand

This block is a purely combinational arithmetic and logic unit for a 32-bit integer datapath. It takes two operands and a 3-bit function code and produces a result word together with a flag that reports whether that result is all zeros. It holds no state and has no clock. A surrounding datapath samples the outputs in the same cycle in which it presents the operands.

The top bit of the function code complements the second operand and also forces a carry of one into the adder. One AND gate, one OR gate and one adder therefore serve both the plain and the complemented forms. The adder with the complemented operand gives subtraction, and its sign bit gives a signed less-than test. The low two bits of the code pick the AND output, the OR output, the adder output or the less-than bit.

There are no data streams here, so no valid/ready handshake applies. All pins are plain control or data levels, and nothing can stall the block.

Top module: `invb_alu`

## Requirements
- R1: Function code 3'b000 drives the result with the bitwise AND of the two operands.
- R2: Function code 3'b001 drives the result with the bitwise OR of the two operands.
- R3: Function code 3'b010 drives the result with the sum of the operands, modulo 2^32.
- R4: Function code 3'b100 gives A AND (NOT B), and code 3'b101 gives A OR (NOT B).
- R5: Function code 3'b110 gives A minus B modulo 2^32, formed as A + ~B + 1.
- R6: Function code 3'b111 puts bit 31 of (A minus B) into result bit 0, with bits 31..1 all zero. Signed overflow is not corrected.
- R7: The unused function code 3'b011 drives a result of zero, whatever the operands are.
- R8: The zero flag is 1 exactly when all 32 result bits are 0.
- R9: The outputs are combinational. They follow a change on any input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, complemented when op_i[2] is 1 |
| op_i | input | 3 | Function code |
| res_o | output | 32 | Result word |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
The hardest case to reach from the ports is a less-than comparison in which the subtraction overflows. In that case the sign bit of the difference is the opposite of the true signed order, and the block must still report the raw sign bit. The stimulus places operands at the extremes of the signed range, such as 0x7FFFFFFF against -1 and 0x80000000 against 1, so that the difference wraps in each direction. A second case is carry propagating through all 32 bits. Adding 0xFFFFFFFF and 1, and subtracting equal operands, both produce an all-zero result and must raise the zero flag.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_LT  = 2'b11
  } res_sel_e;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  output logic [W-1:0] bx_o,
  output logic         cin_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bx_o[i] = b_i[i] ^ inv_i;
  end
  assign cin_o = inv_i;
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  assign sum_o = x_i + y_i + {{(W-1){1'b0}}, cin_i};
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] v_i,
  output logic         z_o
);
  assign z_o = ~|v_i;
endmodule

// File: rtl/invb_alu.sv
module invb_alu
  import alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o,
  output logic            zero_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] bx;
  logic         cin;
  logic [W-1:0] sum;
  res_sel_e     sel;
  logic         inv;

  assign inv = op_i[2];
  assign sel = res_sel_e'(op_i[1:0]);

  alu_operand_prep #(.W(W)) u_prep (
    .b_i   (b_i),
    .inv_i (inv),
    .bx_o  (bx),
    .cin_o (cin)
  );

  alu_adder #(.W(W)) u_add (
    .x_i   (a_i),
    .y_i   (bx),
    .cin_i (cin),
    .sum_o (sum)
  );

  always_comb begin
    unique case (sel)
      SEL_AND: res_o = a_i & bx;
      SEL_OR:  res_o = a_i | bx;
      SEL_SUM: res_o = sum;
      SEL_LT:  res_o = inv ? {{(W-1){1'b0}}, sum[MSB]} : '0;
      default: res_o = '0;
    endcase
  end

  alu_zero_detect #(.W(W)) u_zero (
    .v_i (res_o),
    .z_o (zero_o)
  );

  // Guard checks: operands must be known before anything is compared
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      // R3: a sum, minus the second operand, gives back the first
      if (op_i == 3'b010)
        a_r3_add_inverse: assert (res_o - b_i == a_i)
          else $error("a_r3_add_inverse");
      // R5: a difference, plus the second operand, gives back the first
      if (op_i == 3'b110)
        a_r5_sub_inverse: assert (res_o + b_i == a_i)
          else $error("a_r5_sub_inverse");
      // R6: the less-than result occupies bit 0 only
      if (op_i == 3'b111)
        a_r6_lt_single_bit: assert (res_o[W-1:1] == '0)
          else $error("a_r6_lt_single_bit");
      // R7: the unused code gives zero and raises the flag
      if (op_i == 3'b011)
        a_r7_unused_zero: assert (res_o == '0 && zero_o)
          else $error("a_r7_unused_zero");
      // R8: the flag agrees with the result word
      a_r8_flag_match: assert (zero_o == (res_o == '0))
        else $error("a_r8_flag_match");
    end
  end
endmodule

// File: tb/tb_invb_alu.sv
module tb_invb_alu;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [2:0]  op;
  logic [31:0] res;
  logic        zero;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  invb_alu dut (
    .a_i    (a),
    .b_i    (b),
    .op_i   (op),
    .res_o  (res),
    .zero_o (zero)
  );

  function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] d;
    d = x - y;
    case (f)
      3'b000:  return x & y;
      3'b001:  return x | y;
      3'b010:  return x + y;
      3'b100:  return x & ~y;
      3'b101:  return x | ~y;
      3'b110:  return d;
      3'b111:  return {31'd0, d[31]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%b a=%h b=%h got=%h exp=%h", tag, op, a, b, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] f, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] e;
    @(negedge clk);
    op = f; a = x; b = y;
    #1;
    e = model(f, x, y);
    check(tag, res, e);
    check({tag, "/R8"}, {31'd0, zero}, {31'd0, (e == 32'd0)});
  endtask

  task automatic t_idle;
    apply("R1 idle", 3'b000, 32'd0, 32'd0);
  endtask

  task automatic t_logic;
    apply("R1", 3'b000, 32'hF0F0_1234, 32'hFF00_FF0F);
    apply("R1", 3'b000, 32'hAAAA_AAAA, 32'h5555_5555);
    apply("R2", 3'b001, 32'hF0F0_0000, 32'h0000_0F0F);
    apply("R2", 3'b001, 32'd0, 32'd0);
    apply("R4", 3'b100, 32'hFFFF_FFFF, 32'h0F0F_0F0F);
    apply("R4", 3'b101, 32'h0000_0000, 32'hFFFF_FFFE);
    apply("R4", 3'b101, 32'h1234_5678, 32'h8765_4321);
  endtask

  task automatic t_arith;
    apply("R3", 3'b010, 32'd7, 32'd5);
    apply("R3 wrap", 3'b010, 32'hFFFF_FFFF, 32'd1);
    apply("R3", 3'b010, 32'h8000_0000, 32'h8000_0001);
    apply("R5", 3'b110, 32'd5, 32'd7);
    apply("R5 equal", 3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    apply("R5", 3'b110, 32'd0, 32'h8000_0000);
  endtask

  task automatic t_less_than;
    apply("R6 lt", 3'b111, 32'hFFFF_FFFB, 32'd3);
    apply("R6 ge", 3'b111, 32'd3, 32'hFFFF_FFFB);
    apply("R6 eq", 3'b111, 32'd9, 32'd9);
    apply("R6 ovf pos", 3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply("R6 ovf neg", 3'b111, 32'h8000_0000, 32'd1);
  endtask

  task automatic t_unused;
    apply("R7", 3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply("R7", 3'b011, 32'h1234_5678, 32'h0000_0001);
  endtask

  task automatic t_comb;
    // R9: change inputs mid-cycle, away from any edge
    @(posedge clk);
    #2;
    op = 3'b010; a = 32'd100; b = 32'd23;
    #1;
    check("R9 mid-cycle", res, 32'd123);
    b = 32'd24;
    #1;
    check("R9 follow", res, 32'd124);
  endtask

  initial begin
    a = '0; b = '0; op = '0;
    t_idle();
    t_logic();
    t_arith();
    t_less_than();
    t_unused();
    t_comb();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 10000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule